// File: doc/BRIEF.md
# Privilege-Filtered Event Counter

This block pairs one 32-bit event configuration word with one event counter. The word names an event number and a set of filter bits. On every clock the block reads the current privilege level (0 to 3) and the non-secure flag, and decides from the filter bits whether a pulse of the chosen event may add one to the counter.

The filter is layered. Two base bits suppress counting at levels 1 and 0. When level 3 is built in, two further bits govern the non-secure copies of levels 1 and 0: those levels count only while each of these bits equals its base bit. A separate bit turns on counting at level 2. Level 3 follows the level-1 suppression bit.

Build parameters decide whether level 3, level 2 and multithreading are present, which event numbers below 64 are supported, how wide the event vector is, and how wide the counter is. A bit the build lacks is not stored and reads as zero. When multithreading is present and enabled in the word, a pulse from the sibling thread also counts.

Top module: `evflt_event_counter`

## Requirements
- R1: After a synchronous active-high reset, the configuration reads 0 and the counter reads 0. With that reset word, pulses of event 0 are counted at privilege level 0.
- R2: Bits 31 and 30 always store the written value. Bits 29:28 store it only when level 3 is present, bit 27 only when level 2 is present, and bit 25 only on a multithreaded build. Bits 15:0 always store it. Bits 26 and 24:16 always read 0.
- R3: At level 0, a secure access, or any access on a build without level 3, counts only when bit 30 is 0. A non-secure level-0 access on a build with level 3 counts only when bit 28 equals bit 30.
- R4: At level 1, a secure access, or any access on a build without level 3, counts only when bit 31 is 0. A non-secure level-1 access on a build with level 3 counts only when bit 29 equals bit 31.
- R5: At level 2, counting happens only when bit 27 is 1, so it never happens on a build without level 2.
- R6: At level 3, counting happens only when level 3 is present and bit 31 is 0.
- R7: Only own-thread pulse line `evt_own[n]` counts, where n is bits 15:0. Pulses on other lines are ignored. A number n at or above NUM_EVENTS never counts.
- R8: A number below 64 that is marked unsupported in the build's support mask never counts, and reading the configuration returns that number exactly as written.
- R9: With bit 25 set on a multithreaded build, a pulse on `evt_sib[n]` also counts. A cycle with both the own and the sibling pulse adds only one. With bit 25 clear, or on a build without multithreading, sibling pulses are ignored.
- R10: The counter adds exactly one in each qualifying cycle and wraps from all ones to zero.
- R11: A write and an event pulse in the same cycle are filtered by the word held before the write. The new word takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration word, with bits the build lacks reading 0 |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| non_secure | input | 1 | 1 when the current state is non-secure |
| evt_own | input | NUM_EVENTS | Event pulses from this thread, indexed by event number |
| evt_sib | input | NUM_EVENTS | Event pulses from the sibling thread, indexed by event number |
| cnt_value | output | CNT_W | Event counter |

## Verification
A configuration write and a qualifying pulse can land in the same clock cycle. The bench provokes this by writing a word that sets the level-0 suppression bit in the very cycle that event 3 pulses at secure level 0, then holding the pulse for one more cycle. The result is judged correct only if the counter grows by exactly one: the coinciding pulse counts under the old word, and the following pulse is blocked by the new one. The full filter is also swept over all 32 combinations of the five filter bits, each privilege level and both security states, on a full build and on a minimal build.

// File: rtl/evflt_pkg.sv
package evflt_pkg;

    localparam int CFG_W        = 32;
    localparam int EVNUM_W      = 16;
    localparam int DIRECT_RANGE = 64;

    typedef enum logic [1:0] {
        PRIV_L0 = 2'd0,
        PRIV_L1 = 2'd1,
        PRIV_L2 = 2'd2,
        PRIV_L3 = 2'd3
    } priv_e;

    typedef struct packed {
        logic               kern_off;
        logic               user_off;
        logic               ns_kern;
        logic               ns_user;
        logic               ns_hyp_on;
        logic               rsv_a;
        logic               any_thread;
        logic [8:0]         rsv_b;
        logic [EVNUM_W-1:0] evnum;
    } evcfg_t;

    function automatic logic [CFG_W-1:0] writable_mask(bit has_l3, bit has_l2, bit is_mt);
        logic [CFG_W-1:0] m;
        m = 32'hC000_FFFF;
        if (has_l3) m[29:28] = 2'b11;
        if (has_l2) m[27]    = 1'b1;
        if (is_mt)  m[25]    = 1'b1;
        return m;
    endfunction

    function automatic logic level_allows(
        logic kern_off, logic user_off, logic ns_kern, logic ns_user,
        logic ns_hyp_on, priv_e lvl, logic ns, bit has_l3);
        logic ok;
        case (lvl)
            PRIV_L0: ok = (has_l3 && ns) ? (ns_user == user_off) : !user_off;
            PRIV_L1: ok = (has_l3 && ns) ? (ns_kern == kern_off) : !kern_off;
            PRIV_L2: ok = ns_hyp_on;
            default: ok = has_l3 && !kern_off;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/evflt_cfg_reg.sv
module evflt_cfg_reg
    import evflt_pkg::*;
#(
    parameter bit HAS_L3       = 1'b1,
    parameter bit HAS_L2       = 1'b1,
    parameter bit MULTI_THREAD = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output evcfg_t           cfg
);
    localparam logic [CFG_W-1:0] KEEP = writable_mask(HAS_L3, HAS_L2, MULTI_THREAD);

    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (we) cfg <= evcfg_t'(wdata & KEEP);
    end

    AST_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg)); // R2

endmodule

// File: rtl/evflt_priv_gate.sv
module evflt_priv_gate
    import evflt_pkg::*;
#(
    parameter bit HAS_L3 = 1'b1
) (
    input  logic  kern_off,
    input  logic  user_off,
    input  logic  ns_kern,
    input  logic  ns_user,
    input  logic  ns_hyp_on,
    input  priv_e lvl,
    input  logic  non_secure,
    output logic  allow
);
    always_comb begin
        allow = level_allows(kern_off, user_off, ns_kern, ns_user,
                             ns_hyp_on, lvl, non_secure, HAS_L3);
    end
endmodule

// File: rtl/evflt_evt_select.sv
module evflt_evt_select
    import evflt_pkg::*;
#(
    parameter int                NUM_EVENTS   = 64,
    parameter bit                MULTI_THREAD = 1'b1,
    parameter logic [DIRECT_RANGE-1:0] SUPPORTED_LO = 64'hFFFF_FFFF_FFFF_FF7F
) (
    input  logic [EVNUM_W-1:0]    evnum,
    input  logic                  any_thread,
    input  logic [NUM_EVENTS-1:0] evt_own,
    input  logic [NUM_EVENTS-1:0] evt_sib,
    output logic                  fire
);
    localparam int IDX_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;

    logic             in_range;
    logic             supported;
    logic [IDX_W-1:0] idx;
    logic             sib_ok;

    always_comb begin
        in_range  = int'(evnum) < NUM_EVENTS;
        supported = (int'(evnum) < DIRECT_RANGE) ? SUPPORTED_LO[evnum[5:0]] : 1'b1;
        idx       = evnum[IDX_W-1:0];
        sib_ok    = MULTI_THREAD && any_thread && evt_sib[idx];
        fire      = in_range && supported && (evt_own[idx] || sib_ok);
    end
endmodule

// File: rtl/evflt_counter.sv
module evflt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        inc |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt)); // R10

endmodule

// File: rtl/evflt_event_counter.sv
module evflt_event_counter
    import evflt_pkg::*;
#(
    parameter int   NUM_EVENTS   = 64,
    parameter bit   HAS_L3       = 1'b1,
    parameter bit   HAS_L2       = 1'b1,
    parameter bit   MULTI_THREAD = 1'b1,
    parameter int   CNT_W        = 32,
    parameter logic [63:0] SUPPORTED_LO = 64'hFFFF_FFFF_FFFF_FF7F
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic [1:0]            priv_lvl,
    input  logic                  non_secure,
    input  logic [NUM_EVENTS-1:0] evt_own,
    input  logic [NUM_EVENTS-1:0] evt_sib,
    output logic [CNT_W-1:0]      cnt_value
);
    evcfg_t cfg;
    logic   allow;
    logic   fire;
    logic   inc;

    evflt_cfg_reg #(
        .HAS_L3(HAS_L3), .HAS_L2(HAS_L2), .MULTI_THREAD(MULTI_THREAD)
    ) cfg_i (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
    );

    evflt_priv_gate #(.HAS_L3(HAS_L3)) gate_i (
        .kern_off(cfg.kern_off), .user_off(cfg.user_off),
        .ns_kern(cfg.ns_kern), .ns_user(cfg.ns_user),
        .ns_hyp_on(cfg.ns_hyp_on), .lvl(priv_e'(priv_lvl)),
        .non_secure(non_secure), .allow(allow)
    );

    evflt_evt_select #(
        .NUM_EVENTS(NUM_EVENTS), .MULTI_THREAD(MULTI_THREAD),
        .SUPPORTED_LO(SUPPORTED_LO)
    ) sel_i (
        .evnum(cfg.evnum), .any_thread(cfg.any_thread),
        .evt_own(evt_own), .evt_sib(evt_sib), .fire(fire)
    );

    assign inc = allow && fire;

    evflt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .inc(inc), .cnt(cnt_value)
    );

    assign cfg_rdata = cfg;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[26] == 1'b0 && cfg_rdata[24:16] == 9'd0); // R2
    AST_EL3_GATE: assert property (@(posedge clk) disable iff (rst)
        (priv_lvl == 2'd3 && cfg_rdata[31]) |-> !allow); // R6
    AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !allow |=> $stable(cnt_value)); // R3

    generate
        if (!HAS_L3) begin : g_no_l3
            AST_NO_NS_BITS: assert property (@(posedge clk) disable iff (rst)
                cfg_rdata[29:28] == 2'b00); // R2
        end
        if (!HAS_L2) begin : g_no_l2
            AST_NO_L2_COUNT: assert property (@(posedge clk) disable iff (rst)
                priv_lvl == 2'd2 |-> !allow); // R5
        end
    endgenerate

endmodule

// File: tb/evflt_event_counter_tb.sv
`timescale 1ns/1ps
module evflt_event_counter_tb_top;

    localparam int NE = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we  = 1'b0;
    logic [31:0]   wdata = '0;
    logic [1:0]    lvl = 2'd0;
    logic          ns  = 1'b0;
    logic [NE-1:0] own = '0;
    logic [NE-1:0] sib = '0;
    logic [31:0]   rd_a, rd_b;
    logic [31:0]   cnt_a;
    logic [3:0]    cnt_b;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [31:0] exp_a = 0;
    logic [3:0]  exp_b = 0;

    always #2 clk = ~clk;

    evflt_event_counter dut_i (
        .clk(clk), .rst(rst), .cfg_we(we), .cfg_wdata(wdata), .cfg_rdata(rd_a),
        .priv_lvl(lvl), .non_secure(ns), .evt_own(own), .evt_sib(sib),
        .cnt_value(cnt_a)
    );

    evflt_event_counter #(
        .HAS_L3(1'b0), .HAS_L2(1'b0), .MULTI_THREAD(1'b0), .CNT_W(4)
    ) dut_min_i (
        .clk(clk), .rst(rst), .cfg_we(we), .cfg_wdata(wdata), .cfg_rdata(rd_b),
        .priv_lvl(lvl), .non_secure(ns), .evt_own(own), .evt_sib(sib),
        .cnt_value(cnt_b)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit allow_f(logic [31:0] c, int l, bit s, bit l3);
        case (l)
            0: return (l3 && s) ? (c[28] == c[30]) : !c[30];
            1: return (l3 && s) ? (c[29] == c[31]) : !c[31];
            2: return c[27];
            default: return l3 && !c[31];
        endcase
    endfunction

    task automatic write_cfg(logic [31:0] v);
        @(negedge clk); we = 1'b1; wdata = v;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic pulse_own(int n, int cycles);
        @(negedge clk); own = '0; own[n] = 1'b1;
        repeat (cycles - 1) @(negedge clk);
        @(negedge clk); own = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cfg full", rd_a, 0);
        check("R1 cfg min", rd_b, 0);
        check("R1 cnt full", cnt_a, 0);
        check("R1 cnt min", {28'd0, cnt_b}, 0);
        pulse_own(0, 1);
        check("R1 event0 counts", cnt_a, 1);
        check("R1 event0 counts min", {28'd0, cnt_b}, 1);
        exp_a = 1; exp_b = 1;

        write_cfg(32'hFFFF_FFFF);
        check("R2 mask full", rd_a, 32'hFA00_FFFF);
        check("R2 mask min", rd_b, 32'hC000_FFFF);

        for (int f = 0; f < 32; f++) begin
            for (int l = 0; l < 4; l++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [31:0] c;
                    string tag;
                    c = (32'(f) << 27) | 32'd3;
                    write_cfg(c);
                    lvl = 2'(l); ns = s[0];
                    pulse_own(3, 1);
                    if (allow_f(c, l, s[0], 1'b1)) exp_a++;
                    if (allow_f(c & 32'hC000_FFFF, l, s[0], 1'b0)) exp_b++;
                    tag = (l == 0) ? "R3" : (l == 1) ? "R4" : (l == 2) ? "R5" : "R6";
                    check({tag, " filter full"}, cnt_a, exp_a);
                    check({tag, " filter min"}, {28'd0, cnt_b}, {28'd0, exp_b});
                end
            end
        end
        lvl = 2'd0; ns = 1'b0;

        write_cfg(32'd5);
        @(negedge clk); own = '1; own[5] = 1'b0;
        @(negedge clk); own = '0;
        check("R7 other lines ignored", cnt_a, exp_a);
        pulse_own(5, 1); exp_a++; exp_b++;
        check("R7 selected line", cnt_a, exp_a);
        write_cfg(32'h0000_0100);
        @(negedge clk); own = '1;
        @(negedge clk); own = '0;
        check("R7 out of range", cnt_a, exp_a);
        check("R7 out of range readback", rd_a, 32'h100);

        write_cfg(32'd7);
        @(negedge clk); own = '1;
        @(negedge clk); own = '0;
        check("R8 unsupported no count", cnt_a, exp_a);
        check("R8 unsupported readback", rd_a, 32'd7);

        write_cfg(32'h0200_0002);
        @(negedge clk); sib[2] = 1'b1;
        @(negedge clk); sib = '0;
        exp_a++;
        check("R9 sibling counts", cnt_a, exp_a);
        check("R9 sibling ignored min", {28'd0, cnt_b}, {28'd0, exp_b});
        @(negedge clk); sib[2] = 1'b1; own[2] = 1'b1;
        @(negedge clk); sib = '0; own = '0;
        exp_a++; exp_b++;
        check("R9 both add one", cnt_a, exp_a);
        write_cfg(32'h0000_0002);
        @(negedge clk); sib[2] = 1'b1;
        @(negedge clk); sib = '0;
        check("R9 sibling off", cnt_a, exp_a);

        write_cfg(32'd1);
        pulse_own(1, 20);
        exp_a = exp_a + 20; exp_b = exp_b + 4'd4;
        check("R10 per cycle", cnt_a, exp_a);
        check("R10 wrap min", {28'd0, cnt_b}, {28'd0, exp_b});

        write_cfg(32'd3);
        @(negedge clk); we = 1'b1; wdata = 32'h4000_0003; own[3] = 1'b1;
        @(negedge clk); we = 1'b0;
        @(negedge clk); own = '0;
        exp_a++; exp_b++;
        check("R11 old word on write cycle", cnt_a, exp_a);
        check("R11 old word min", {28'd0, cnt_b}, {28'd0, exp_b});

        finish_run();
    end

endmodule